// File: doc/BRIEF.md
# 3×3 Cluster Zero-Suppression Filter

This block sits after the hit-threshold stage of a pixel sensor readout. It takes pixel samples in raster order, one per clock, each carrying a signal value and a hit flag. For every pixel whose hit flag is set, it emits one cluster record. A record holds the row and column of that pixel, the values of the 3×3 patch centred on it, a mask of patch positions that fall off the matrix, and the number of the frame. Pixels that lie in no hit's patch are never forwarded, so the downstream link carries only clusters and not the whole matrix.

Two line buffers, each as long as a row, keep the two rows before the current one. A 3×3 shift window is fed from those buffers and from the input, so the patch under examination is centred one row and one column behind the newest pixel. The rows and columns of the frame are parameters. Records wait in a small FIFO behind a valid/ready output. If a record is produced while the FIFO is full, that record is lost and a saturating drop counter is incremented.

A two-state controller sequences the frames. In `ST_STREAM` the input is ready and every accepted pixel moves the window. The transition *last pixel accepted* goes to `ST_FLUSH`. In that state the input is held off, and the block pushes COLS+1 zero pixels with no hit, so that the patches around the bottom row can complete. The transition *flush done* returns to `ST_STREAM`, clears the row and column counters and advances the frame number.

Top module: `cluster_filter`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `drop_cnt` is 0, and the first frame is numbered 0.
- R2: Each accepted pixel whose `in_hit` is 1 yields exactly one record, with `out_row`/`out_col` equal to that pixel's position. A frame with no hit yields no record. Records leave in the raster order of their centres.
- R3: The patch value at row offset dr and column offset dc (each 0, 1 or 2, where 0 is above or left, 1 is the centre, and 2 is below or right) appears at `out_vals[(3*dr+dc)*W +: W]`.
- R4: Bit 3*dr+dc of `out_mask` is 1 exactly when that patch position lies outside the frame, and the value at that position is then 0. The centre bit (bit 4) is never set.
- R5: `out_frame` gives the number of the frame the centre pixel belongs to. The number counts up by one per frame from 0 and wraps at FRW bits.
- R6: After the last pixel of a frame is accepted, `in_ready` stays 0 for exactly COLS+1 cycles, and then the next frame is accepted.
- R7: Cycles in which `in_valid` is 0 in `ST_STREAM` leave the pixel position unchanged and do not alter the records.
- R8: Hits that touch each other each yield their own full record, with no merging.
- R9: The FIFO holds up to FDEPTH records. A record produced while FDEPTH records are held is discarded and `drop_cnt` is incremented. The counter saturates at all ones and never decreases.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and every record field hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel sample present |
| in_ready | output | 1 | Pixel accepted this cycle when set together with in_valid |
| in_val | input | W | Pixel signal value |
| in_hit | input | 1 | Pixel crossed threshold |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_frame | output | FRW | Frame number of the record |
| out_row | output | RW | Centre row |
| out_col | output | CW | Centre column |
| out_mask | output | 9 | Off-matrix flags, bit 3*dr+dc |
| out_vals | output | 9*W | Patch values, row-major |
| drop_cnt | output | DCW | Saturating count of discarded records |

## Verification
The filter runs on a 4×5 frame. A frame with no hits checks that the suppression leaves nothing, and a sweep that places one hit at each of the 20 positions in turn checks every corner, edge and interior case of the mask and of the patch order. A checkerboard frame with idle input cycles checks diagonal neighbours and the handling of gaps. A frame that is all hits, first with the consumer ready and then with it stalled, separates "every hit gets its own record" from FIFO overflow, the drop count, and the holding of a stalled record.

// File: rtl/cz_pkg.sv
package cz_pkg;
    typedef enum logic {ST_STREAM, ST_FLUSH} cz_state_e;
    localparam int CZ_TAPS = 9;
    localparam int CZ_SIDE = 3;
endpackage

// File: rtl/cz_linewin.sv
module cz_linewin #(
    parameter int W    = 12,
    parameter int COLS = 640,
    parameter int CW   = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift,
    input  logic [CW-1:0]                 col,
    input  logic [W-1:0]                  din,
    input  logic                          din_hit,
    output logic [cz_pkg::CZ_TAPS*W-1:0]  win,
    output logic                          ctr_hit
);
    localparam int S = cz_pkg::CZ_SIDE;

    logic [W:0]   row_a [COLS];
    logic [W-1:0] row_b [COLS];
    logic [W-1:0] tap [S][S];
    logic         hit_mid, hit_new;
    logic [W:0]   rd_a;
    logic [W-1:0] rd_b;

    assign rd_a = row_a[col];
    assign rd_b = row_b[col];

    always_ff @(posedge clk) begin
        if (shift) begin
            row_a[col] <= {din_hit, din};
            row_b[col] <= rd_a[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < S; r++)
                for (int c = 0; c < S; c++)
                    tap[r][c] <= '0;
            hit_mid <= 1'b0;
            hit_new <= 1'b0;
        end else if (shift) begin
            for (int r = 0; r < S; r++) begin
                tap[r][0] <= tap[r][1];
                tap[r][1] <= tap[r][2];
            end
            tap[0][2] <= rd_b;
            tap[1][2] <= rd_a[W-1:0];
            tap[2][2] <= din;
            hit_new   <= rd_a[W];
            hit_mid   <= hit_new;
        end
    end

    for (genvar gr = 0; gr < S; gr++) begin : g_row
        for (genvar gc = 0; gc < S; gc++) begin : g_col
            assign win[(S*gr+gc)*W +: W] = tap[gr][gc];
        end
    end

    assign ctr_hit = hit_mid;
endmodule

// File: rtl/cz_recfifo.sv
module cz_recfifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 4,
    parameter int DCW   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic           rd_valid,
    input  logic           rd_ready,
    output logic [DW-1:0]  rd_data,
    output logic [DCW-1:0] drop_cnt
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW  = $clog2(DEPTH + 1);

    logic [DW-1:0] slot [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [NW-1:0] fill;
    logic          take, pop;

    assign take     = wr_en && (fill < NW'(DEPTH));
    assign pop      = rd_valid && rd_ready;
    assign rd_valid = (fill != '0);
    assign rd_data  = slot[rp];

    always_ff @(posedge clk) begin
        if (take) slot[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            fill     <= '0;
            drop_cnt <= '0;
        end else begin
            if (take) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            fill <= fill + NW'(take) - NW'(pop);
            if (wr_en && !take && !(&drop_cnt))
                drop_cnt <= drop_cnt + DCW'(1);
        end
    end
endmodule

// File: rtl/cluster_filter.sv
module cluster_filter #(
    parameter int ROWS   = 360,
    parameter int COLS   = 640,
    parameter int W      = 12,
    parameter int FDEPTH = 4,
    parameter int FRW    = 8,
    parameter int DCW    = 16,
    localparam int RW    = $clog2(ROWS + 2),
    localparam int CW    = $clog2(COLS),
    localparam int NT    = cz_pkg::CZ_TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [W-1:0]    in_val,
    input  logic            in_hit,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [FRW-1:0]  out_frame,
    output logic [RW-1:0]   out_row,
    output logic [CW-1:0]   out_col,
    output logic [NT-1:0]   out_mask,
    output logic [NT*W-1:0] out_vals,
    output logic [DCW-1:0]  drop_cnt
);
    import cz_pkg::*;

    localparam int VW   = NT * W;
    localparam int RECW = FRW + RW + CW + NT + VW;

    cz_state_e state_q, state_d;
    logic          push, virt, frame_end;
    logic [RW-1:0] ir_q, cr_d, cr_q;
    logic [CW-1:0] ic_q, cc_d, cc_q;
    logic [FRW-1:0] fr_q, cfr_q;
    logic          cok_d, cok_q, new_q;
    logic [VW-1:0] win, vals_z;
    logic          ctr_hit;
    logic [NT-1:0] mask;
    logic          wr_en;
    logic [RECW-1:0] wr_rec, rd_rec;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STREAM;
        else        state_q <= state_d;
    end

    // controller outputs and next state
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        push      = 1'b0;
        virt      = 1'b0;
        frame_end = 1'b0;
        unique case (state_q)
            ST_STREAM: begin
                in_ready = 1'b1;
                push     = in_valid;
                if (in_valid && ir_q == RW'(ROWS-1) && ic_q == CW'(COLS-1))
                    state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                push = 1'b1;
                virt = 1'b1;
                if (ir_q == RW'(ROWS+1)) begin
                    frame_end = 1'b1;
                    state_d   = ST_STREAM;
                end
            end
            default: state_d = ST_STREAM;
        endcase
    end

    // raster position and frame number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            ic_q <= '0;
            fr_q <= '0;
        end else if (push) begin
            if (frame_end) begin
                ir_q <= '0;
                ic_q <= '0;
                fr_q <= fr_q + FRW'(1);
            end else if (ic_q == CW'(COLS-1)) begin
                ic_q <= '0;
                ir_q <= ir_q + RW'(1);
            end else begin
                ic_q <= ic_q + CW'(1);
            end
        end
    end

    // centre lags the input by one row and one column
    always_comb begin
        if (ic_q == '0) begin
            cr_d  = ir_q - RW'(2);
            cc_d  = CW'(COLS-1);
            cok_d = (ir_q >= RW'(2));
        end else begin
            cr_d  = ir_q - RW'(1);
            cc_d  = ic_q - CW'(1);
            cok_d = (ir_q >= RW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= 1'b0;
            cok_q <= 1'b0;
            cr_q  <= '0;
            cc_q  <= '0;
            cfr_q <= '0;
        end else begin
            new_q <= push;
            if (push) begin
                cok_q <= cok_d;
                cr_q  <= cr_d;
                cc_q  <= cc_d;
                cfr_q <= fr_q;
            end
        end
    end

    cz_linewin #(.W(W), .COLS(COLS), .CW(CW)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (push),
        .col    (ic_q),
        .din    (virt ? '0 : in_val),
        .din_hit(virt ? 1'b0 : in_hit),
        .win    (win),
        .ctr_hit(ctr_hit)
    );

    // edge mask and zero fill
    always_comb begin
        for (int k = 0; k < NT; k++) begin
            mask[k] = ((k / 3) == 0 && cr_q == '0) ||
                      ((k / 3) == 2 && cr_q == RW'(ROWS-1)) ||
                      ((k % 3) == 0 && cc_q == '0) ||
                      ((k % 3) == 2 && cc_q == CW'(COLS-1));
            vals_z[k*W +: W] = mask[k] ? '0 : win[k*W +: W];
        end
    end

    assign wr_en  = new_q && cok_q && ctr_hit;
    assign wr_rec = {cfr_q, cr_q, cc_q, mask, vals_z};

    cz_recfifo #(.DW(RECW), .DEPTH(FDEPTH), .DCW(DCW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_rec),
        .rd_valid(out_valid),
        .rd_ready(out_ready),
        .rd_data (rd_rec),
        .drop_cnt(drop_cnt)
    );

    assign {out_frame, out_row, out_col, out_mask, out_vals} = rd_rec;
endmodule

// File: rtl/cz_checker.sv
module cz_checker #(
    parameter int ROWS = 360,
    parameter int COLS = 640,
    parameter int W    = 12,
    parameter int FRW  = 8,
    parameter int DCW  = 16,
    parameter int RW   = 9,
    parameter int CW   = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            out_valid,
    input logic            out_ready,
    input logic [FRW-1:0]  out_frame,
    input logic [RW-1:0]   out_row,
    input logic [CW-1:0]   out_col,
    input logic [8:0]      out_mask,
    input logic [9*W-1:0]  out_vals,
    input logic [DCW-1:0]  drop_cnt
);
    logic [9*W-1:0] mexp;
    always_comb begin
        for (int k = 0; k < 9; k++) mexp[k*W +: W] = {W{out_mask[k]}};
    end

    // R10
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vals) && $stable(out_mask)
            && $stable(out_row) && $stable(out_col) && $stable(out_frame));

    // R9
    drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> drop_cnt >= $past(drop_cnt));

    // R4
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vals & mexp) == '0);

    // R4
    centre_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_mask[4]);

    // R2
    coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_row < RW'(ROWS)) && (out_col < CW'(COLS)));
endmodule

bind cluster_filter cz_checker #(
    .ROWS(ROWS), .COLS(COLS), .W(W), .FRW(FRW), .DCW(DCW), .RW(RW), .CW(CW)
) u_cz_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_frame(out_frame),
    .out_row  (out_row),
    .out_col  (out_col),
    .out_mask (out_mask),
    .out_vals (out_vals),
    .drop_cnt (drop_cnt)
);

// File: tb/test_cluster_filter.sv
module test_cluster_filter;
    localparam int CLK_P  = 10;
    localparam int ROWS   = 4;
    localparam int COLS   = 5;
    localparam int W      = 8;
    localparam int FDEPTH = 4;
    localparam int FRW    = 8;
    localparam int DCW    = 16;
    localparam int RW     = $clog2(ROWS + 2);
    localparam int CW     = $clog2(COLS);
    localparam int RECW   = FRW + RW + CW + 9 + 9*W;

    logic            clk, rst_n, in_valid, in_ready, in_hit, out_valid, out_ready;
    logic [W-1:0]    in_val;
    logic [FRW-1:0]  out_frame;
    logic [RW-1:0]   out_row;
    logic [CW-1:0]   out_col;
    logic [8:0]      out_mask;
    logic [9*W-1:0]  out_vals;
    logic [DCW-1:0]  drop_cnt;

    cluster_filter #(.ROWS(ROWS), .COLS(COLS), .W(W), .FDEPTH(FDEPTH), .FRW(FRW), .DCW(DCW))
    i_cluster_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_val(in_val), .in_hit(in_hit), .out_valid(out_valid), .out_ready(out_ready),
        .out_frame(out_frame), .out_row(out_row), .out_col(out_col),
        .out_mask(out_mask), .out_vals(out_vals), .drop_cnt(drop_cnt)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int vecs = 0;
    int errs = 0;
    int fnum = 0;
    bit done = 0;
    bit hitmap [ROWS][COLS];
    logic [RECW-1:0] expq [$];

    function automatic logic [W-1:0] pv(int f, int r, int c);
        return W'((f*37 + r*11 + c*3 + 1) % 256);
    endfunction

    function automatic logic [RECW-1:0] mkrec(int f, int r, int c);
        logic [8:0]     m;
        logic [9*W-1:0] v;
        for (int k = 0; k < 9; k++) begin
            int nr = r + k/3 - 1;
            int nc = c + k%3 - 1;
            if (nr < 0 || nr >= ROWS || nc < 0 || nc >= COLS) begin
                m[k] = 1'b1;
                v[k*W +: W] = '0;
            end else begin
                m[k] = 1'b0;
                v[k*W +: W] = pv(f, nr, nc);
            end
        end
        return {FRW'(f % 256), RW'(r), CW'(c), m, v};
    endfunction

    task automatic check(bit ok, string msg);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_map();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                hitmap[r][c] = 1'b0;
    endtask

    task automatic send_frame(bit gap, int limit);
        int n = 0;
        int lows = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (hitmap[r][c] && (limit < 0 || n < limit)) begin
                    expq.push_back(mkrec(fnum, r, c));
                    n++;
                end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_val   = pv(fnum, r, c);
                in_hit   = hitmap[r][c];
                while (!in_ready) @(negedge clk);
                if (gap && ((r*COLS + c) % 3 == 1) && !(r == ROWS-1 && c == COLS-1)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_hit   = 1'b1;
                end
            end
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready && lows < 100) begin
            lows++;
            @(negedge clk);
        end
        // R6
        check(lows == COLS+1, $sformatf("R6 flush stall got %0d exp %0d", lows, COLS+1));
        fnum++;
    endtask

    // record monitor, sampled a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n && out_valid && out_ready) begin
            logic [RECW-1:0] got, e;
            got = {out_frame, out_row, out_col, out_mask, out_vals};
            if (expq.size() == 0) begin
                check(1'b0, $sformatf("R2 unexpected record got %h exp none", got));
            end else begin
                e = expq.pop_front();
                check(got == e, $sformatf("R3 R4 R5 record got %h exp %h", got, e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            vecs++;
            $display("FAIL watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_val = '0;
        in_hit = 1'b0;
        out_ready = 1'b1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1 && out_valid == 1'b0 && drop_cnt == '0,
              $sformatf("R1 reset got rdy=%b vld=%b drop=%0d exp 1 0 0", in_ready, out_valid, drop_cnt));

        // R2: nothing leaves an empty frame
        clear_map();
        send_frame(1'b0, -1);
        idle(5);
        check(expq.size() == 0, $sformatf("R2 empty frame pending got %0d exp 0", expq.size()));

        // R3 R4 R5: one hit per frame at every position
        for (int p = 0; p < ROWS*COLS; p++) begin
            clear_map();
            hitmap[p / COLS][p % COLS] = 1'b1;
            send_frame(1'b0, -1);
        end
        idle(10);
        check(expq.size() == 0, $sformatf("R2 sweep pending got %0d exp 0", expq.size()));

        // R7 R8: checkerboard with idle input cycles
        clear_map();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                hitmap[r][c] = ((r + c) % 2 == 0);
        send_frame(1'b1, -1);
        idle(10);
        check(expq.size() == 0, $sformatf("R7 gap frame pending got %0d exp 0", expq.size()));

        // R8: every pixel a hit, consumer ready
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                hitmap[r][c] = 1'b1;
        send_frame(1'b0, -1);
        idle(10);
        check(expq.size() == 0, $sformatf("R8 dense frame pending got %0d exp 0", expq.size()));

        // R9 R10: every pixel a hit, consumer stalled
        out_ready = 1'b0;
        send_frame(1'b0, FDEPTH);
        idle(5);
        check(drop_cnt == DCW'(ROWS*COLS - FDEPTH),
              $sformatf("R9 drops got %0d exp %0d", drop_cnt, ROWS*COLS - FDEPTH));
        check(out_valid == 1'b1, $sformatf("R10 stalled valid got %b exp 1", out_valid));
        out_ready = 1'b1;
        idle(10);
        check(expq.size() == 0, $sformatf("R9 kept records pending got %0d exp 0", expq.size()));
        check(out_valid == 1'b0, $sformatf("R9 fifo empty got vld=%b exp 0", out_valid));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule